// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

A memory-mapped machine timer for a cluster of harts. One free-running 64-bit time counter is shared by all harts. Each hart has its own 64-bit compare register. The counter advances by one on every clock cycle in which the timebase tick input is high.

Each hart drives a level-sensitive timer interrupt. The interrupt is high for as long as that hart's compare value is less than or equal to the current time. Software writes a compare value through a 32-bit register bus, one half at a time. The interrupt is evaluated again right after each half-write and on every cycle after that, so a compare value set in the past fires at once. A compare value in the future fires when the counter reaches it.

The time value is read as two words. Reading the low word also captures the high word in a shadow register. A later read of the high word returns that captured value, so the two halves belong to the same instant.

Top module: `hart_mtimer`

## Requirements
- R1: After reset the time counter and every compare register are zero, the read data output is zero, and every hart interrupt is high, because a compare of 0 is not above a time of 0.
- R2: The time counter increases by exactly one on each clock edge where `tick_i` is high. It keeps its value on edges where `tick_i` is low.
- R3: The compare register of hart h sits at byte offset 8*h. Its bits 31:0 are at offset +0 and its bits 63:32 are at offset +4. Reading either half returns the last value written to it.
- R4: A write to one half of a compare register leaves the other half unchanged. The new 64-bit value is formed from the written half and the held half.
- R5: `timer_irq_o[h]` is high exactly when compare h <= time. It takes its new value in the cycle after any compare half-write, including a write that sets the compare at or below the current time.
- R6: When compare h is above the current time, `timer_irq_o[h]` stays low. It goes high in the first cycle in which the counter equals compare h.
- R7: A read at offset 0x7FF8 returns time bits 31:0 and captures time bits 63:32 into a shadow register. A read at 0x7FFC returns the shadow value from the most recent low-word read, or zero if no low-word read has happened since reset.
- R8: Writes to offsets 0x7FF8 and 0x7FFC do not change the time counter.
- R9: Reads return zero, and writes change nothing, when the offset is unmapped, when the slot index is at or above `NUM_HARTS`, or when byte address bits 1:0 are not zero.
- R10: Read data is registered. It appears on `rsp_rdata_o` on the clock edge that accepts the read, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable; the counter advances on each edge where it is high |
| req_valid_i | input | 1 | Bus access strobe, one access per cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW (15) | Byte offset within the 0x8000-byte window |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data |
| timer_irq_o | output | NUM_HARTS | Level timer interrupt, one per hart |

## Verification
The assertions take two things for granted. First, the 64-bit counter never wraps within a run, so an interrupt that is high stays high until its compare register is written. Second, the counter moves only under `tick_i`. The stimulus keeps to both: every run starts from a zero counter and lasts a few thousand cycles, and compare values are drawn close to the current time so that interrupts switch in both directions. The random mix also sends accesses to slots past the hart count, to unaligned offsets and to the read-only time words. This exercises the paths where an access must be ignored.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned SLOT_MAX = 4095;  // last 8-byte slot holds the time words
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned TIME_W   = 64;
  typedef logic [TIME_W-1:0] tval_t;
endpackage

// File: rtl/mtc_time_ctr.sv
module mtc_time_ctr
  import mtc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  output tval_t time_o
);
  tval_t time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (tick_i) time_q <= time_q + tval_t'(1);
  end

  assign time_o = time_q;

  AST_TIME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> time_o == $past(time_o) + tval_t'(1));  // R2
  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_o));  // R2
endmodule

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned NUM_HARTS = 4,
  localparam int unsigned IDX_W    = AW - 3
) (
  input  logic             valid_i,
  input  logic [AW-1:0]    addr_i,
  output logic             cmp_hit_o,
  output logic             time_hit_o,
  output logic             hi_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] TIME_IDX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] HART_LIM = IDX_W'(NUM_HARTS);

  logic aligned;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign idx_o      = addr_i[AW-1:3];
  assign hi_o       = addr_i[2];
  assign cmp_hit_o  = valid_i && aligned && (idx_o < HART_LIM);
  assign time_hit_o = valid_i && aligned && (idx_o == TIME_IDX);

  AST_DEC_EXCL: assert final (!(cmp_hit_o && time_hit_o));  // R9
endmodule

// File: rtl/mtc_cmp_slot.sv
module mtc_cmp_slot
  import mtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  tval_t             time_i,
  output tval_t             cmp_o,
  output logic              irq_o
);
  tval_t cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (wr_lo_i)  cmp_q[31:0]  <= wdata_i;
    else if (wr_hi_i)  cmp_q[63:32] <= wdata_i;
  end

  assign cmp_o = cmp_q;
  // level compare, re-evaluated every cycle from registered state
  assign irq_o = (cmp_q <= time_i);

  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cmp_o[63:32] == $past(cmp_o[63:32]));  // R4
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> cmp_o[31:0] == $past(cmp_o[31:0]));  // R4
  AST_PAST_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && ({cmp_o[63:32], wdata_i} <= time_i)) |=> irq_o);  // R5
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_lo_i && !wr_hi_i) |=> irq_o);  // R6
endmodule

// File: rtl/hart_mtimer.sv
module hart_mtimer
  import mtc_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned AW        = 15,
  localparam int unsigned IDX_W    = AW - 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 req_valid_i,
  input  logic                 req_we_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic [NUM_HARTS-1:0] timer_irq_o
);
  initial AST_HART_RANGE: assert (NUM_HARTS >= 1 && NUM_HARTS <= SLOT_MAX);  // R9

  tval_t             time_w;
  tval_t             cmp_w [NUM_HARTS];
  logic              cmp_hit, time_hit, hi_sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shadow_q, rdata_d;
  logic              rd_en;

  mtc_time_ctr u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .time_o(time_w)
  );

  mtc_decode #(.AW(AW), .NUM_HARTS(NUM_HARTS)) u_dec (
    .valid_i   (req_valid_i),
    .addr_i    (req_addr_i),
    .cmp_hit_o (cmp_hit),
    .time_hit_o(time_hit),
    .hi_o      (hi_sel),
    .idx_o     (idx)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    logic sel;
    assign sel = req_we_i && cmp_hit && (idx == IDX_W'(h));
    mtc_cmp_slot u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(sel && !hi_sel),
      .wr_hi_i(sel && hi_sel),
      .wdata_i(req_wdata_i),
      .time_i (time_w),
      .cmp_o  (cmp_w[h]),
      .irq_o  (timer_irq_o[h])
    );
  end

  assign rd_en = req_valid_i && !req_we_i;

  always_comb begin
    rdata_d = '0;
    if (cmp_hit) begin
      for (int h = 0; h < NUM_HARTS; h++)
        if (idx == IDX_W'(h)) rdata_d = hi_sel ? cmp_w[h][63:32] : cmp_w[h][31:0];
    end else if (time_hit) begin
      rdata_d = hi_sel ? shadow_q : time_w[31:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_rdata_o <= '0;
      shadow_q    <= '0;
    end else if (rd_en) begin
      rsp_rdata_o <= rdata_d;
      if (time_hit && !hi_sel) shadow_q <= time_w[63:32];
    end
  end

  AST_RD_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !cmp_hit && !time_hit) |=> rsp_rdata_o == '0);  // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rsp_rdata_o));  // R10
  AST_TIME_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && time_hit && !tick_i) |=> $stable(time_w));  // R8
  AST_TIME_LO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && time_hit && !hi_sel) |=> rsp_rdata_o == $past(time_w[31:0]));  // R7
endmodule

// File: tb/sim_hart_mtimer.sv
module sim_hart_mtimer;
  localparam int NH = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick = 1'b0;
  logic          valid = 1'b0;
  logic          we = 1'b0;
  logic [14:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NH-1:0] irq;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];
  logic [31:0] m_shadow;
  logic [31:0] m_rd;

  always #2 clk = ~clk;  // 250 MHz

  hart_mtimer #(.NUM_HARTS(NH), .AW(15)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .req_valid_i(valid), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wdata), .rsp_rdata_o(rdata), .timer_irq_o(irq)
  );

  function automatic logic [31:0] exp_read(input logic [14:0] a);
    int idx = int'(a[14:3]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (idx < NH) return a[2] ? m_cmp[idx][63:32] : m_cmp[idx][31:0];
    if (idx == 4095) return a[2] ? m_shadow : m_time[31:0];
    return 32'h0;
  endfunction

  function automatic logic [NH-1:0] exp_irq();
    logic [NH-1:0] r;
    for (int h = 0; h < NH; h++) r[h] = (m_cmp[h] <= m_time);
    return r;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; model updated from pre-edge state, then outputs sampled
  task automatic step(input string tag, input logic v, input logic w,
                      input logic [14:0] a, input logic [31:0] d, input logic tk);
    int idx = int'(a[14:3]);
    @(negedge clk);
    valid = v; we = w; addr = a; wdata = d; tick = tk;
    @(posedge clk);
    if (v && !w) begin
      m_rd = exp_read(a);
      if (a[1:0] == 2'b00 && idx == 4095 && !a[2]) m_shadow = m_time[63:32];
    end
    if (v && w && a[1:0] == 2'b00 && idx < NH) begin
      if (a[2]) m_cmp[idx][63:32] = d;
      else      m_cmp[idx][31:0]  = d;
    end
    if (tk) m_time = m_time + 64'd1;
    #1;
    check32({tag, " rdata (R10)"}, rdata, m_rd);
    check32({tag, " irq (R5)"}, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic idle(input string tag, input logic tk);
    step(tag, 1'b0, 1'b0, 15'h0, 32'h0, tk);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    m_time = '0; m_shadow = '0; m_rd = '0;
    for (int h = 0; h < NH; h++) m_cmp[h] = '0;
    seed = $urandom(32'h1c0ffee);
    #10 rst_ni = 1'b1;
    #1;
    // R1: reset state
    check32("R1 rdata", rdata, 32'h0);
    check32("R1 irq all high", 32'(irq), 32'hF);
    step("R1", 1'b1, 1'b0, 15'h7FF8, 32'h0, 1'b0);
    step("R1", 1'b1, 1'b0, 15'h0008, 32'h0, 1'b0);
    // R2: counting
    for (int i = 0; i < 5; i++) idle("R2", 1'b1);
    idle("R2", 1'b0);
    step("R2", 1'b1, 1'b0, 15'h7FF8, 32'h0, 1'b0);
    check32("R2 time", rdata, 32'd5);
    // R3 / R4: halves
    step("R3", 1'b1, 1'b1, 15'h0008, 32'h1234_5678, 1'b0);
    step("R3", 1'b1, 1'b1, 15'h000C, 32'h0000_0009, 1'b0);
    step("R3", 1'b1, 1'b0, 15'h0008, 32'h0, 1'b0);
    check32("R3 lo", rdata, 32'h1234_5678);
    step("R3", 1'b1, 1'b0, 15'h000C, 32'h0, 1'b0);
    check32("R3 hi", rdata, 32'h9);
    step("R4", 1'b1, 1'b1, 15'h0008, 32'hAAAA_0001, 1'b0);
    step("R4", 1'b1, 1'b0, 15'h000C, 32'h0, 1'b0);
    check32("R4 hi kept", rdata, 32'h9);
    // R5: past value fires at once, future value clears
    step("R5", 1'b1, 1'b1, 15'h0014, 32'h1, 1'b0);
    check32("R5 future low", 32'(irq[2]), 32'h0);
    step("R5", 1'b1, 1'b1, 15'h0010, 32'h0, 1'b0);
    step("R5", 1'b1, 1'b1, 15'h0014, 32'h0, 1'b0);
    check32("R5 past high", 32'(irq[2]), 32'h1);
    // R6: future compare reached by counter
    step("R6", 1'b1, 1'b1, 15'h0018, m_time[31:0] + 32'd6, 1'b0);
    check32("R6 not yet", 32'(irq[3]), 32'h0);
    for (int i = 0; i < 8; i++) idle("R6", 1'b1);
    check32("R6 reached", 32'(irq[3]), 32'h1);
    // R7: shadowed high word
    step("R7", 1'b1, 1'b0, 15'h7FF8, 32'h0, 1'b1);
    step("R7", 1'b1, 1'b0, 15'h7FFC, 32'h0, 1'b1);
    check32("R7 hi", rdata, 32'h0);
    // R8: time writes ignored
    step("R8", 1'b1, 1'b1, 15'h7FF8, 32'hFFFF_0000, 1'b0);
    step("R8", 1'b1, 1'b1, 15'h7FFC, 32'h0000_00FF, 1'b0);
    step("R8", 1'b1, 1'b0, 15'h7FF8, 32'h0, 1'b0);
    check32("R8 time kept", rdata, m_time[31:0]);
    // R9: misses
    step("R9", 1'b1, 1'b0, 15'h0020, 32'h0, 1'b0);
    check32("R9 slot beyond", rdata, 32'h0);
    step("R9", 1'b1, 1'b1, 15'h0009, 32'hFFFF_FFFF, 1'b0);
    step("R9", 1'b1, 1'b0, 15'h0009, 32'h0, 1'b0);
    check32("R9 unaligned", rdata, 32'h0);
    step("R9", 1'b1, 1'b0, 15'h4000, 32'h0, 1'b0);
    step("R9", 1'b1, 1'b0, 15'h0008, 32'h0, 1'b0);
    check32("R9 slot1 intact", rdata, 32'hAAAA_0001);
    // R10: hold across idle
    for (int i = 0; i < 3; i++) idle("R10", 1'b1);
    check32("R10 hold", rdata, 32'hAAAA_0001);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned kind = $urandom % 4;
      int unsigned slot = $urandom % 6;
      logic        hi   = 1'($urandom % 2);
      logic        w    = 1'($urandom % 2);
      logic [14:0] a;
      logic [31:0] d;
      if (kind < 2)       a = {12'(slot), hi, 2'b00};
      else if (kind == 2) a = {12'hFFF, hi, 2'b00};
      else                a = 15'($urandom);
      if (hi) d = (($urandom % 4) == 0) ? 32'h1 : 32'h0;
      else    d = m_time[31:0] + 32'($urandom % 24) - 32'd12;
      step("R5 rand", ($urandom % 4) != 0, w, a, d, 1'($urandom % 2));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule